// File: doc/BRIEF.md
# Pin Configuration Lock Register

This block is a single 32-bit register that freezes the configuration of individual pins on a 16-pin I/O port. Software chooses which pins to protect by writing one lock bit per pin. Those bits have no effect until a separate key bit is armed. The key can be armed only by a fixed five-access pattern on the register bus. Once armed, the key stays set until reset, and no write can change the register.

While the key is set, the block drives a 16-bit mask equal to the pin lock bits. It uses this mask to suppress configuration-write requests for the locked pins. The port configuration registers sit next to this block: they present one write request per pin and act only on the granted request.

The bus is single-cycle and word-wide. It has a select, a write enable, a read enable, write data and combinational read data.

Top module: `pin_lock_reg`

## Requirements
- R1: After reset, the read data is 0x0000_0000 and the lock mask is all zeros.
- R2: The read word carries the pin lock bits in bits 15:0 and the key bit in bit 16. Bits 31:17 always read as zero.
- R3: While the key is 0, a selected write loads bits 15:0 of the write data into the pin lock bits. Write data bit 16 never sets the key directly.
- R4: The key arms only after this exact sequence of selected accesses: a write with bit 16 = 1, a write with bit 16 = 0, a write with bit 16 = 1, a read, and a read. The first read returns bit 16 = 0 and puts the lock into effect. The second read returns bit 16 = 1.
- R5: If the pin lock bits in any write of the sequence differ from those in the first write, the sequence aborts and the key stays 0.
- R6: A step out of order aborts the sequence and leaves the key at 0. This covers a read before the third write, or a write whose bit 16 is not the expected value.
- R7: Once the key is 1, every write is ignored: the pin lock bits and the key keep their values until reset.
- R8: The lock mask equals the pin lock bits when the key is 1, and is all zeros when the key is 0.
- R9: For every pin y, the configuration-write grant is the request with bit y cleared wherever mask bit y is set.
- R10: An access with the select low is not a step of the key sequence and does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, valid with sel |
| rd_en | input | 1 | Read strobe, valid with sel |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| cfg_wr_req | input | 16 | Per-pin configuration write requests |
| cfg_wr_gnt | output | 16 | Requests left after locked pins are removed |
| lock_mask | output | 16 | Pins currently locked |

## Verification
The assertions assume that the bus never raises write and read together in a selected cycle. The design gives the write priority if that happens, but the key-sequence properties are written for one access per cycle. The bench drives every access through a write task or a read task. Each task raises exactly one strobe with the select for one clock, and between accesses all strobes are low. Unselected accesses are issued only with the select low, so they cannot count as a sequence step.

// File: rtl/pin_lock_pkg.sv
package pin_lock_pkg;

  typedef enum logic [2:0] {
    KS_IDLE,
    KS_ONE,
    KS_ZERO,
    KS_TWO,
    KS_DONE
  } key_state_e;

  // Advance the key sequence by one bus access.
  function automatic key_state_e key_next(
    input key_state_e st,
    input logic       is_wr,
    input logic       is_rd,
    input logic       key_bit,
    input logic       lk_same
  );
    key_state_e nx;
    nx = st;
    unique case (st)
      KS_IDLE: if (is_wr && key_bit) nx = KS_ONE;
      KS_ONE: begin
        if (is_wr && !key_bit && lk_same) nx = KS_ZERO;
        else if (is_wr || is_rd)          nx = KS_IDLE;
      end
      KS_ZERO: begin
        if (is_wr && key_bit && lk_same) nx = KS_TWO;
        else if (is_wr || is_rd)         nx = KS_IDLE;
      end
      KS_TWO: begin
        if (is_rd)      nx = KS_DONE;
        else if (is_wr) nx = KS_IDLE;
      end
      KS_DONE: nx = KS_DONE;
      default: nx = KS_IDLE;
    endcase
    return nx;
  endfunction

  // Arm event: the first read after the third write.
  function automatic logic key_arms(input key_state_e st, input logic is_rd);
    return (st == KS_TWO) && is_rd;
  endfunction

endpackage

// File: rtl/lock_key_fsm.sv
module lock_key_fsm
  import pin_lock_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic             key_bit,
  input  logic [NPINS-1:0] lk_in,
  output logic             arm
);

  key_state_e       st_q;
  key_state_e       st_d;
  logic [NPINS-1:0] ref_q;
  logic             lk_same;

  assign lk_same = (lk_in == ref_q);
  assign st_d    = key_next(st_q, wr_stb, rd_stb, key_bit, lk_same);
  assign arm     = key_arms(st_q, rd_stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= KS_IDLE;
      ref_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == KS_IDLE && wr_stb && key_bit) ref_q <= lk_in;
    end
  end

endmodule

// File: rtl/lock_bits_reg.sv
module lock_bits_reg #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [NPINS-1:0] wr_lk,
  input  logic             arm,
  output logic [NPINS-1:0] lk_q,
  output logic             lkk_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q  <= '0;
      lkk_q <= 1'b0;
    end else begin
      if (wr_stb && !lkk_q) lk_q <= wr_lk;
      if (arm)              lkk_q <= 1'b1;
    end
  end

endmodule

// File: rtl/lock_gate.sv
module lock_gate #(
  parameter int NPINS = 16
) (
  input  logic             lkk,
  input  logic [NPINS-1:0] lk,
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] mask,
  output logic [NPINS-1:0] gnt
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign mask[i] = lkk & lk[i];
    assign gnt[i]  = req[i] & ~mask[i];
  end

endmodule

// File: rtl/pin_lock_reg.sv
module pin_lock_reg #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] cfg_wr_req,
  output logic [NPINS-1:0] cfg_wr_gnt,
  output logic [NPINS-1:0] lock_mask
);

  localparam int KEY_POS = NPINS;

  logic             wr_stb;
  logic             rd_stb;
  logic             arm;
  logic [NPINS-1:0] lk_q;
  logic             lkk_q;

  // A write wins if both strobes are raised together.
  assign wr_stb = sel & wr_en;
  assign rd_stb = sel & rd_en & ~wr_en;

  lock_key_fsm #(.NPINS(NPINS)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .key_bit (wdata[KEY_POS]),
    .lk_in   (wdata[NPINS-1:0]),
    .arm     (arm)
  );

  lock_bits_reg #(.NPINS(NPINS)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .wr_lk  (wdata[NPINS-1:0]),
    .arm    (arm),
    .lk_q   (lk_q),
    .lkk_q  (lkk_q)
  );

  lock_gate #(.NPINS(NPINS)) u_gate (
    .lkk  (lkk_q),
    .lk   (lk_q),
    .req  (cfg_wr_req),
    .mask (lock_mask),
    .gnt  (cfg_wr_gnt)
  );

  always_comb begin
    rdata                = '0;
    rdata[NPINS-1:0]     = lk_q;
    rdata[KEY_POS]       = lkk_q;
  end

endmodule

// File: rtl/lock_reg_checker.sv
module lock_reg_checker #(
  parameter int NPINS = 16,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic [DW-1:0]    rdata,
  input logic [NPINS-1:0] cfg_wr_req,
  input logic [NPINS-1:0] cfg_wr_gnt,
  input logic [NPINS-1:0] lock_mask,
  input logic [NPINS-1:0] lk,
  input logic             lkk,
  input logic             arm
);

  assert_single_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> !(wr_en && rd_en));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:NPINS+1] == '0);

  assert_arm_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lkk) |-> $past(sel && rd_en && !wr_en));

  assert_arm_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> (rdata[NPINS] == 1'b0));

  assert_key_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lkk |=> lkk);

  assert_lk_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lkk |=> $stable(lk));

  assert_mask_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lkk |-> (lock_mask == '0));

  assert_mask_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lkk |-> (lock_mask == rdata[NPINS-1:0]));

  assert_gnt_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_gnt & lock_mask) == '0);

  assert_gnt_subset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_gnt & ~cfg_wr_req) == '0);

  assert_unselected_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(lk) && $stable(lkk)));

endmodule

bind pin_lock_reg lock_reg_checker #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rdata      (rdata),
  .cfg_wr_req (cfg_wr_req),
  .cfg_wr_gnt (cfg_wr_gnt),
  .lock_mask  (lock_mask),
  .lk         (lk_q),
  .lkk        (lkk_q),
  .arm        (arm)
);

// File: tb/pin_lock_reg_bench.sv
`timescale 1ns/1ps
module pin_lock_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] cfg_wr_req = '0;
  logic [15:0] cfg_wr_gnt;
  logic [15:0] lock_mask;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pin_lock_reg u_pin_lock_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .cfg_wr_req (cfg_wr_req),
    .cfg_wr_gnt (cfg_wr_gnt),
    .lock_mask  (lock_mask)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic s = 1'b1);
    @(negedge clk);
    sel = s; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(output logic [31:0] d, input logic s = 1'b1);
    @(negedge clk);
    sel = s; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] key_word(input logic key, input logic [15:0] lk);
    return {15'd0, key, lk};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 mask", {16'd0, lock_mask}, 32'h0);

    // R2/R3 reserved bits and field layout
    wr(32'hFFFE_FFFF);
    rd(r);
    chk("R2 R3 all ones", r, 32'h0000_FFFF);
    for (int i = 0; i < 16; i++) begin
      wr(32'h1 << i);
      rd(r);
      chk("R3 walking one", r, 32'h1 << i);
    end
    wr(32'h0001_0000);
    rd(r);
    chk("R3 key bit not direct", r, 32'h0);

    // R10 unselected write ignored
    wr(32'h0000_1234);
    wr(32'h0001_5555, 1'b0);
    rd(r);
    chk("R10 unselected write", r, 32'h0000_1234);

    // R8/R9 unlocked: no mask, grants pass through
    #1;
    chk("R8 mask while unlocked", {16'd0, lock_mask}, 32'h0);
    cfg_wr_req = 16'hFFFF; #1;
    chk("R9 grants while unlocked", {16'd0, cfg_wr_gnt}, 32'h0000_FFFF);
    cfg_wr_req = '0;

    // R5 changed lock bits mid-sequence
    wr(key_word(1, 16'h00F0));
    wr(key_word(0, 16'h00F1));
    wr(key_word(1, 16'h00F0));
    rd(r); rd(r2);
    chk("R5 lk mismatch first read", r, 32'h0000_00F0);
    chk("R5 lk mismatch second read", r2, 32'h0000_00F0);
    wr(key_word(1, 16'h0F00));
    wr(key_word(0, 16'h0F00));
    wr(key_word(1, 16'h0FF0));
    rd(r); rd(r2);
    chk("R5 third write mismatch", r2, 32'h0000_0FF0);

    // R6 out-of-order steps
    wr(key_word(1, 16'h3333));
    rd(r);
    wr(key_word(0, 16'h3333));
    wr(key_word(1, 16'h3333));
    rd(r); rd(r2);
    chk("R6 early read", r2, 32'h0000_3333);
    wr(key_word(1, 16'h4444));
    wr(key_word(1, 16'h4444));
    wr(key_word(1, 16'h4444));
    rd(r); rd(r2);
    chk("R6 wrong key second write", r2, 32'h0000_4444);
    wr(key_word(1, 16'h5555));
    wr(key_word(0, 16'h5555));
    wr(key_word(0, 16'h5555));
    rd(r); rd(r2);
    chk("R6 wrong key third write", r2, 32'h0000_5555);
    wr(key_word(1, 16'h6666));
    wr(key_word(0, 16'h6666));
    wr(key_word(1, 16'h6666));
    wr(key_word(1, 16'h6666));
    rd(r); rd(r2);
    chk("R6 write instead of read", r2, 32'h0000_6666);
    #1;
    chk("R8 mask after aborts", {16'd0, lock_mask}, 32'h0);

    // R4 full sequence, with an unselected read between (R10)
    wr(key_word(1, 16'hA5C3));
    wr(key_word(0, 16'hA5C3));
    wr(key_word(1, 16'hA5C3));
    rd(r, 1'b0);
    rd(r);
    chk("R4 first read key zero", r, 32'h0000_A5C3);
    rd(r2);
    chk("R4 second read key one", r2, 32'h0001_A5C3);

    // R8 mask and R9 exhaustive request sweep
    #1;
    chk("R8 mask locked", {16'd0, lock_mask}, 32'h0000_A5C3);
    for (int q = 0; q < 65536; q++) begin
      cfg_wr_req = 16'(q);
      #1;
      chk("R9 gated grant", {16'd0, cfg_wr_gnt}, {16'd0, 16'(q) & ~16'hA5C3});
    end
    cfg_wr_req = '0;

    // R7 writes ignored while locked
    wr(32'h0000_0000);
    rd(r);
    chk("R7 clear write ignored", r, 32'h0001_A5C3);
    wr(key_word(1, 16'h0001));
    wr(key_word(0, 16'h0001));
    wr(key_word(1, 16'h0001));
    rd(r); rd(r2);
    chk("R7 resequence ignored", r2, 32'h0001_A5C3);
    #1;
    chk("R7 mask held", {16'd0, lock_mask}, 32'h0000_A5C3);

    // R1/R7 reset releases the lock
    do_reset();
    #1;
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 mask after reset", {16'd0, lock_mask}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule